// File: doc/BRIEF.md
# Transmit Packet Framer

This block turns a payload held in a transmit byte queue into a framed outgoing byte stream. A packet starts with a run of preamble bytes. A sync word follows, sent as two bytes or as the same two bytes twice. The payload bytes pulled from the upstream valid/ready port come next. An optional two-byte checksum closes the packet. Optional PN9 whitening scrambles the payload and the checksum. The preamble and the sync word are never whitened.

The framer samples its configuration only when `start` is raised while it is idle. Those values hold for the whole packet. The configuration covers the preamble length, the sync pattern, sync doubling, checksum enable, whitening enable and payload length. The preamble and the sync word always travel together: no setting sends one without the other. The downstream side is a registered valid/ready byte port with a flag that marks the final byte of the packet.

Top module: `tx_framer`

## Requirements
- R1: After reset, `out_valid`, `out_last`, `in_ready` and `busy` are all low.
- R2: After an accepted start, the packet begins with P bytes of value 0xAA, where P is `cfg_pre_len`. A value of 0 is sent as one byte, so the preamble is never absent.
- R3: The sync word follows the preamble as `cfg_sync[15:8]` then `cfg_sync[7:0]`. When `cfg_sync_dbl` is 1, that pair is sent twice, giving four bytes.
- R4: Exactly L payload bytes are taken, in arrival order, on cycles where `in_valid` and `in_ready` are both high. L is `cfg_pay_len`, and a value of 0 takes one byte. `in_ready` is high only in the data phase.
- R5: When `cfg_crc_en` is 1, two checksum bytes follow the data, high byte first. The checksum is CRC-16 with polynomial 0x8005 and initial value 0xFFFF, fed MSB first with the unwhitened payload bytes only. When `cfg_crc_en` is 0, no checksum bytes are sent.
- R6: When `cfg_white_en` is 1, each data byte and each checksum byte k (counted from 0 at the first data byte) is XORed with mask k. Bit i of mask k is generator output o[8k+i], with o[0..8] = 1 and o[n] = o[n-9] XOR o[n-4] (x^9 + x^5 + 1, all-ones seed each packet). The first mask is therefore 0xFF.
- R7: `out_last` is high together with `out_valid` on the final byte of each packet and on no other byte.
- R8: The configuration is captured when `start` is high while `busy` is low. Configuration changes and `start` pulses while `busy` is high do not affect the current packet and do not begin another.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a packet (honoured only when idle) |
| cfg_pre_len | input | LEN_W | Preamble byte count |
| cfg_sync | input | 16 | Sync pattern, high byte sent first |
| cfg_sync_dbl | input | 1 | Send the sync pair twice |
| cfg_crc_en | input | 1 | Append the two-byte checksum |
| cfg_white_en | input | 1 | Whiten data and checksum |
| cfg_pay_len | input | LEN_W | Payload byte count |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte available |
| in_ready | output | 1 | Framer takes the payload byte |
| out_data | output | 8 | Framed byte |
| out_valid | output | 1 | Framed byte available |
| out_ready | input | 1 | Downstream takes the framed byte |
| out_last | output | 1 | Final byte of the packet |
| busy | output | 1 | Packet in progress |

## Verification
The assertions assume that `rst` is high before the first clock edge. They also assume that `in_data` depends on nothing but the upstream queue. They take no account of a downstream that withdraws `out_ready` in a way that matters: holding of the output is checked whatever `out_ready` does. The bench changes every input just after a rising edge and samples just before the next one. It holds payload bytes at the queue head until they are taken, and it changes configuration and raises `start` mid-packet only to show that these have no effect.

// File: rtl/tx_framer_pkg.sv
package tx_framer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_PREAMBLE = 3'd1,
    ST_SYNC     = 3'd2,
    ST_DATA     = 3'd3,
    ST_CRC      = 3'd4,
    ST_DONE     = 3'd5
  } fr_state_t;

  localparam int BYTE_W = 8;
  localparam int SYNC_W = 16;
endpackage

// File: rtl/tx_framer_crc16.sv
module tx_framer_crc16 #(
  parameter int          CRC_W = 16,
  parameter int          DIN_W = 8,
  parameter logic [15:0] POLY  = 16'h8005,
  parameter logic [15:0] INIT  = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             upd,
  input  logic [DIN_W-1:0] din,
  output logic [CRC_W-1:0] crc
);
  logic [CRC_W-1:0] crc_nxt;

  // byte-wide update, most significant input bit first
  always_comb begin
    crc_nxt = crc;
    for (int i = DIN_W - 1; i >= 0; i--) begin
      crc_nxt = {crc_nxt[CRC_W-2:0], 1'b0} ^
                ({CRC_W{crc_nxt[CRC_W-1] ^ din[i]}} & POLY[CRC_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) crc <= INIT[CRC_W-1:0];
    else if (upd)    crc <= crc_nxt;
  end
endmodule

// File: rtl/tx_framer_pn9.sv
module tx_framer_pn9 #(
  parameter int         STEPS = 8,
  parameter logic [8:0] SEED  = 9'h1FF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             adv,
  output logic [STEPS-1:0] mask
);
  logic [8:0] lfsr, lfsr_nxt;

  // output bit is lfsr[0]; feedback enters at the top
  always_comb begin
    lfsr_nxt = lfsr;
    for (int i = 0; i < STEPS; i++) begin
      lfsr_nxt = {lfsr_nxt[0] ^ lfsr_nxt[5], lfsr_nxt[8:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || init) lfsr <= SEED;
    else if (adv)    lfsr <= lfsr_nxt;
  end

  // the next STEPS output bits are the low state bits, first bit in bit 0
  assign mask = lfsr[STEPS-1:0];
endmodule

// File: rtl/tx_framer_ctrl.sv
module tx_framer_ctrl
  import tx_framer_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] pre_len,
  input  logic [LEN_W-1:0] pay_len,
  input  logic             sync_dbl,
  input  logic             crc_en,
  input  logic             adv,
  input  logic             in_valid,
  output fr_state_t        state,
  output logic [LEN_W-1:0] cnt,
  output logic             emit,
  output logic             take,
  output logic             last
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  fr_state_t        state_nxt;
  logic [LEN_W-1:0] cnt_nxt;
  logic             pre_end, pay_end, sync_end;

  assign pre_end  = (pre_len == '0) || (cnt == pre_len - ONE);
  assign pay_end  = (pay_len == '0) || (cnt == pay_len - ONE);
  assign sync_end = (cnt == (sync_dbl ? LEN_W'(3) : ONE));

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    emit      = 1'b0;
    take      = 1'b0;
    last      = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          state_nxt = ST_PREAMBLE;
          cnt_nxt   = '0;
        end
      end
      ST_PREAMBLE: begin
        if (adv) begin
          emit = 1'b1;
          if (pre_end) begin
            state_nxt = ST_SYNC;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt + ONE;
          end
        end
      end
      ST_SYNC: begin
        if (adv) begin
          emit = 1'b1;
          if (sync_end) begin
            state_nxt = ST_DATA;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt + ONE;
          end
        end
      end
      ST_DATA: begin
        if (adv && in_valid) begin
          emit = 1'b1;
          take = 1'b1;
          if (pay_end) begin
            last      = !crc_en;
            state_nxt = crc_en ? ST_CRC : ST_DONE;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt + ONE;
          end
        end
      end
      ST_CRC: begin
        if (adv) begin
          emit = 1'b1;
          if (cnt == ONE) begin
            last      = 1'b1;
            state_nxt = ST_DONE;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt + ONE;
          end
        end
      end
      ST_DONE: begin
        if (adv) state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_nxt;
      cnt   <= cnt_nxt;
    end
  end
endmodule

// File: rtl/tx_framer.sv
module tx_framer
  import tx_framer_pkg::*;
#(
  parameter int          LEN_W    = 8,
  parameter int          DEF_PRE  = 4,
  parameter logic [7:0]  PRE_BYTE = 8'hAA,
  parameter logic [15:0] CRC_POLY = 16'h8005,
  parameter logic [15:0] CRC_INIT = 16'hFFFF,
  parameter logic [8:0]  PN9_SEED = 9'h1FF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [LEN_W-1:0] cfg_pre_len,
  input  logic [15:0]      cfg_sync,
  input  logic             cfg_sync_dbl,
  input  logic             cfg_crc_en,
  input  logic             cfg_white_en,
  input  logic [LEN_W-1:0] cfg_pay_len,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_last,
  output logic             busy
);
  localparam int CFG_W = 2 * LEN_W + SYNC_W + 3;

  // configuration held for the whole packet
  logic [LEN_W-1:0]  pre_q, pay_q;
  logic [SYNC_W-1:0] sync_q;
  logic              dbl_q, crc_q, white_q;
  logic [CFG_W-1:0]  cfg_flat;

  fr_state_t        state;
  logic [LEN_W-1:0] cnt;
  logic             start_ok, adv, emit, take, last;
  logic [15:0]      crc;
  logic [7:0]       wmask, tx_byte, crc_byte;
  fr_state_t        out_kind;

  assign start_ok = start && (state == ST_IDLE);
  assign adv      = !out_valid || out_ready;
  assign busy     = (state != ST_IDLE);
  assign in_ready = (state == ST_DATA) && adv;
  assign cfg_flat = {pre_q, pay_q, sync_q, dbl_q, crc_q, white_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= LEN_W'(DEF_PRE);
      pay_q   <= LEN_W'(1);
      sync_q  <= '0;
      dbl_q   <= 1'b1;
      crc_q   <= 1'b1;
      white_q <= 1'b0;
    end else if (start_ok) begin
      pre_q   <= cfg_pre_len;
      pay_q   <= cfg_pay_len;
      sync_q  <= cfg_sync;
      dbl_q   <= cfg_sync_dbl;
      crc_q   <= cfg_crc_en;
      white_q <= cfg_white_en;
    end
  end

  tx_framer_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start_ok),
    .pre_len  (pre_q),
    .pay_len  (pay_q),
    .sync_dbl (dbl_q),
    .crc_en   (crc_q),
    .adv      (adv),
    .in_valid (in_valid),
    .state    (state),
    .cnt      (cnt),
    .emit     (emit),
    .take     (take),
    .last     (last)
  );

  tx_framer_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk  (clk),
    .rst  (rst),
    .init (start_ok),
    .upd  (take),
    .din  (in_data),
    .crc  (crc)
  );

  tx_framer_pn9 #(.STEPS(8), .SEED(PN9_SEED)) u_pn9 (
    .clk  (clk),
    .rst  (rst),
    .init (start_ok),
    .adv  (emit && ((state == ST_DATA) || (state == ST_CRC))),
    .mask (wmask)
  );

  assign crc_byte = cnt[0] ? crc[7:0] : crc[15:8];

  always_comb begin
    case (state)
      ST_PREAMBLE: tx_byte = PRE_BYTE;
      ST_SYNC:     tx_byte = cnt[0] ? sync_q[7:0] : sync_q[15:8];
      ST_DATA:     tx_byte = in_data  ^ (white_q ? wmask : 8'h00);
      ST_CRC:      tx_byte = crc_byte ^ (white_q ? wmask : 8'h00);
      default:     tx_byte = 8'h00;
    endcase
  end

  // registered output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= 8'h00;
      out_kind  <= ST_IDLE;
    end else if (emit) begin
      out_valid <= 1'b1;
      out_last  <= last;
      out_data  <= tx_byte;
      out_kind  <= state;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/tx_framer_chk.sv
module tx_framer_chk
  import tx_framer_pkg::*;
#(
  parameter int         LEN_W    = 8,
  parameter logic [7:0] PRE_BYTE = 8'hAA
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic                     out_last,
  input logic [7:0]               out_data,
  input logic                     in_ready,
  input logic                     busy,
  input fr_state_t                out_kind,
  input logic [2*LEN_W+SYNC_W+2:0] cfg_flat
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_last && !busy));

  // R2
  preamble_value_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == ST_PREAMBLE) |-> (out_data == PRE_BYTE));

  // R4
  in_ready_phase_chk: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (busy && (!out_valid || out_ready)));

  // R7
  last_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cfg_flat));

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

bind tx_framer tx_framer_chk #(.LEN_W(LEN_W), .PRE_BYTE(PRE_BYTE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_last  (out_last),
  .out_data  (out_data),
  .in_ready  (in_ready),
  .busy      (busy),
  .out_kind  (out_kind),
  .cfg_flat  (cfg_flat)
);

// File: tb/tx_framer_bench.sv
module tx_framer_bench;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic             rst, start;
  logic [LEN_W-1:0] cfg_pre_len, cfg_pay_len;
  logic [15:0]      cfg_sync;
  logic             cfg_sync_dbl, cfg_crc_en, cfg_white_en;
  logic [7:0]       in_data, out_data;
  logic             in_valid, in_ready, out_valid, out_ready, out_last, busy;

  tx_framer u_tx_framer (
    .clk(clk), .rst(rst), .start(start),
    .cfg_pre_len(cfg_pre_len), .cfg_sync(cfg_sync), .cfg_sync_dbl(cfg_sync_dbl),
    .cfg_crc_en(cfg_crc_en), .cfg_white_en(cfg_white_en), .cfg_pay_len(cfg_pay_len),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_last(out_last), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int pn_bits[0:4095];
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] pay_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", cycles, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] pn_mask(input int k);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = pn_bits[8*k+i][0];
    return m;
  endfunction

  function automatic logic [15:0] ref_crc(input logic [7:0] d[$]);
    int c;
    c = 16'hFFFF;
    foreach (d[j]) begin
      for (int b = 7; b >= 0; b--) begin
        int top;
        top = ((c >> 15) & 1) ^ ((d[j] >> b) & 1);
        c = (c << 1) & 16'hFFFF;
        if (top != 0) c = c ^ 16'h8005;
      end
    end
    return c[15:0];
  endfunction

  task automatic build(input int pre, input logic [15:0] sy, input bit dbl,
                       input bit crc, input bit wh, input int len);
    logic [7:0] raw[$];
    logic [15:0] c;
    int n;
    int p;
    exp_q.delete(); tag_q.delete(); pay_q.delete();
    n = (len == 0) ? 1 : len;
    p = (pre == 0) ? 1 : pre;
    for (int i = 0; i < p; i++) begin exp_q.push_back(8'hAA); tag_q.push_back("R2"); end
    for (int r = 0; r < (dbl ? 2 : 1); r++) begin
      exp_q.push_back(sy[15:8]); tag_q.push_back("R3");
      exp_q.push_back(sy[7:0]);  tag_q.push_back("R3");
    end
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      v = 8'((i * 37 + len * 11 + 5) & 255);
      raw.push_back(v);
      pay_q.push_back(v);
      exp_q.push_back(wh ? (v ^ pn_mask(i)) : v);
      tag_q.push_back(wh ? "R6" : "R4");
    end
    if (crc) begin
      c = ref_crc(raw);
      exp_q.push_back(wh ? (c[15:8] ^ pn_mask(n))   : c[15:8]); tag_q.push_back("R5");
      exp_q.push_back(wh ? (c[7:0]  ^ pn_mask(n+1)) : c[7:0]);  tag_q.push_back("R5");
    end
  endtask

  // called just after a rising edge
  task automatic run_pkt(input int pre, input logic [15:0] sy, input bit dbl,
                         input bit crc, input bit wh, input int len,
                         input bit rnd_ready, input bit rnd_valid, input bit disturb);
    int guard;
    build(pre, sy, dbl, crc, wh, len);
    cfg_pre_len = LEN_W'(pre); cfg_sync = sy; cfg_sync_dbl = dbl;
    cfg_crc_en = crc; cfg_white_en = wh; cfg_pay_len = LEN_W'(len);
    start = 1'b1;
    in_valid = 1'b0; out_ready = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
    guard = 0;
    while ((exp_q.size() > 0 || busy) && guard < 4000) begin
      in_valid  = (pay_q.size() > 0) && (!rnd_valid || ($urandom_range(0, 99) < 60));
      in_data   = (pay_q.size() > 0) ? pay_q[0] : 8'h00;
      out_ready = !rnd_ready || ($urandom_range(0, 99) < 60);
      if (disturb && (guard == 4 || guard == 9 || guard == 15)) begin
        // R8: changes and start while busy must have no effect
        cfg_pre_len = 8'd9; cfg_sync = ~sy; cfg_sync_dbl = ~dbl;
        cfg_crc_en = ~crc; cfg_white_en = ~wh; cfg_pay_len = 8'd3;
        start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (in_valid && in_ready) void'(pay_q.pop_front());
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R7", "byte after end of packet", int'(out_data), 0);
        end else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_data == e, t, "output byte", int'(out_data), int'(e));
          chk(out_last == (exp_q.size() == 0), "R7", "last flag",
              int'(out_last), int'(exp_q.size() == 0));
        end
      end
      @(posedge clk); #1;
      guard++;
    end
    start = 1'b0;
    chk(exp_q.size() == 0, "R4", "bytes missing from packet", exp_q.size(), 0);
    chk(pay_q.size() == 0, "R4", "payload bytes not taken", pay_q.size(), 0);
    in_valid = 1'b1; in_data = 8'h5A; out_ready = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!out_valid && !in_ready, "R8", "no output while idle",
          int'({out_valid, in_ready}), 0);
      @(posedge clk); #1;
    end
    in_valid = 1'b0;
  endtask

  initial begin
    for (int n = 0; n < 4096; n++) pn_bits[n] = (n < 9) ? 1 : (pn_bits[n-9] ^ pn_bits[n-4]);
    rst = 1'b1; start = 1'b0; in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b0;
    cfg_pre_len = 8'd4; cfg_sync = 16'hD391; cfg_sync_dbl = 1'b1;
    cfg_crc_en = 1'b1; cfg_white_en = 1'b0; cfg_pay_len = 8'd4;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!out_valid && !out_last && !in_ready && !busy, "R1", "reset state",
        int'({out_valid, out_last, in_ready, busy}), 0);
    chk(pn_mask(0) == 8'hFF, "R6", "first whitening mask", int'(pn_mask(0)), 8'hFF);
    @(posedge clk); #1;

    run_pkt(4, 16'hD391, 1, 1, 0, 5,   0, 0, 0);
    run_pkt(0, 16'h1234, 0, 0, 0, 1,   0, 0, 0);
    run_pkt(3, 16'hB00F, 1, 1, 1, 16,  1, 1, 0);
    run_pkt(2, 16'h7E81, 0, 0, 1, 8,   1, 0, 0);
    run_pkt(5, 16'hC33C, 1, 1, 1, 20,  1, 1, 1);
    run_pkt(1, 16'h0FF0, 0, 1, 0, 0,   0, 1, 0);
    run_pkt(6, 16'hA5A5, 0, 1, 1, 255, 1, 1, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule